// File: doc/BRIEF.md
# LCD Controller Register and Interrupt Unit

This block is the software-visible face of a simple LCD controller. A 32-bit register bus reaches six word registers: control, three timing words, status and subpanel. The block stores what software writes under fixed keep-masks and returns it with constant bits ORed in. It decodes the fields that the rest of the controller uses: load mode, panel type, mono, enable, active width and height, and the subpanel word. These fields are exported as plain outputs.

The block also keeps three status flags: frame-done, palette-done and sync-error. A frame-setup engine sets these flags with one-cycle pulses, and enable transitions written through the control register also act on them. The flags drive one registered, level-sensitive interrupt. Two of the sources can be masked and one cannot.

Top module: `panel_ctl_regs`

## Requirements
- R1: Only byte offsets 0x00 (control), 0x04 (timing0), 0x08 (timing1), 0x0C (timing2), 0x10 (status) and 0x14 (subpanel) are mapped. A read of any other offset returns 0, and a write to any other offset changes no register, flag or output.
- R2: A control write takes load mode from bits 21:20, the panel-type flag from bit 7, the interrupt enables from bits 4:3, mono from bit 1 and enable from bit 0. It keeps the word ANDed with 0x01CFF300. A control read returns those fields at the same positions, with the panel-type flag repeated at bit 23, ORed with the kept bits and with 0xFE000C34.
- R3: A timing0 or timing1 write sets width or height to (bits 9:0) + 1, giving a range of 1 to 1024, and keeps bits 31:10. A read returns the kept bits in 31:10 and (size - 1) mod 1024 in bits 9:0. Timing0 reads also OR in 0x0000000F.
- R4: Timing2 keeps the whole written word and reads back ORed with 0xFC000000. Subpanel keeps the written word ANDed with 0xA1FFFFFF and reads back unchanged.
- R5: A status read returns palette-done in bit 6, sync-error in bit 2 and frame-done in bit 0, with all other bits zero. Writes to status change nothing.
- R6: The interrupt is high in a cycle when, one cycle earlier, any of these held: frame-done with enable bit 3, palette-done with enable bit 4, or sync-error. Sync-error needs no enable. With no flag set, the interrupt is low.
- R7: A control write that changes enable from 1 to 0 clears sync-error. It also sets frame-done, unless that same write carries load mode 1. A control write that leaves enable unchanged does not act on the flags.
- R8: A control write that changes enable from 0 to 1 clears frame-done and palette-done.
- R9: Each flag-set pulse from the engine sets its flag at the next edge. When an enable transition falls in the same cycle as a pulse, the transition's effect on the flags wins.
- R10: After reset, all fields, sizes, flags, the subpanel register, the interrupt and read data are zero. In that state, control reads 0xFE000C34, timing0 and timing1 read 0x000003FF, and timing2 reads 0xFC000000.
- R11: Read data appears on the clock edge after the read strobe and holds until the next read. A read and a write in the same cycle return the value from before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Single-cycle write strobe |
| bus_rd | input | 1 | Single-cycle read strobe |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, one cycle after the read strobe |
| evt_frame_done | input | 1 | Pulse that sets frame-done |
| evt_palette_done | input | 1 | Pulse that sets palette-done |
| evt_sync_error | input | 1 | Pulse that sets sync-error |
| irq | output | 1 | Registered level interrupt |
| load_mode | output | 2 | Decoded load mode |
| tft | output | 1 | Decoded panel-type flag |
| mono | output | 1 | Decoded mono flag |
| enable | output | 1 | Decoded controller enable |
| width | output | 11 | Active width, 1 to 1024, or 0 after reset |
| height | output | 11 | Active height, 1 to 1024, or 0 after reset |
| subpanel | output | 32 | Masked subpanel word |

## Verification
The two functions that collide are an engine pulse that sets a flag and a control write whose enable transition clears or sets that same flag. The bench forces both into one cycle. It disables the controller while a sync-error pulse arrives, and it enables the controller while frame-done and palette-done pulses arrive. It then reads status and the interrupt and expects the transition's outcome. The random phase also lets pulses land on random control writes, and it compares every read against a model that applies pulses first and the transition second.

// File: rtl/lcdr_pkg.sv
package lcdr_pkg;

    localparam int REG_ADDR_W    = 8;
    localparam int DATA_W        = 32;
    localparam int SIZE_FIELD_W  = 10;
    localparam int SIZE_W        = SIZE_FIELD_W + 1;
    localparam int HI_W          = DATA_W - SIZE_FIELD_W;

    localparam logic [REG_ADDR_W-1:0] OFF_CTRL = 8'h00;
    localparam logic [REG_ADDR_W-1:0] OFF_T0   = 8'h04;
    localparam logic [REG_ADDR_W-1:0] OFF_T1   = 8'h08;
    localparam logic [REG_ADDR_W-1:0] OFF_T2   = 8'h0C;
    localparam logic [REG_ADDR_W-1:0] OFF_STAT = 8'h10;
    localparam logic [REG_ADDR_W-1:0] OFF_SUB  = 8'h14;

    localparam logic [DATA_W-1:0] CTRL_KEEP_MASK = 32'h01CF_F300;
    localparam logic [DATA_W-1:0] CTRL_FIXED     = 32'hFE00_0C34;
    localparam logic [DATA_W-1:0] T0_FIXED       = 32'h0000_000F;
    localparam logic [DATA_W-1:0] T2_FIXED       = 32'hFC00_0000;
    localparam logic [DATA_W-1:0] SUB_KEEP_MASK  = 32'hA1FF_FFFF;

    typedef struct packed {
        logic [1:0]        load_mode;
        logic              tft;
        logic [1:0]        irq_en;
        logic              mono;
        logic              enable;
        logic [DATA_W-1:0] ctrl_rest;
        logic [SIZE_W-1:0] width;
        logic [SIZE_W-1:0] height;
        logic [HI_W-1:0]   t0_hi;
        logic [HI_W-1:0]   t1_hi;
        logic [DATA_W-1:0] t2;
        logic [DATA_W-1:0] subpanel;
    } cfg_t;

    typedef struct packed {
        logic frame_done;
        logic palette_done;
        logic sync_err;
    } flags_t;

    typedef struct packed {
        logic rise;
        logic fall;
        logic fall_sets_done;
    } en_evt_t;

    function automatic logic [SIZE_W-1:0] size_from(input logic [DATA_W-1:0] w);
        return SIZE_W'(w[SIZE_FIELD_W-1:0]) + SIZE_W'(1);
    endfunction

    function automatic logic [SIZE_FIELD_W-1:0] size_field(input logic [SIZE_W-1:0] s);
        logic [SIZE_W-1:0] m;
        m = s - SIZE_W'(1);
        return m[SIZE_FIELD_W-1:0];
    endfunction

    function automatic logic [DATA_W-1:0] read_word(input logic [REG_ADDR_W-1:0] a,
                                                    input cfg_t c, input flags_t f);
        logic [DATA_W-1:0] r;
        r = '0;
        case (a)
            OFF_CTRL: begin
                r[23]    = c.tft;
                r[21:20] = c.load_mode;
                r[7]     = c.tft;
                r[4:3]   = c.irq_en;
                r[1]     = c.mono;
                r[0]     = c.enable;
                r        = r | c.ctrl_rest | CTRL_FIXED;
            end
            OFF_T0:   r = {c.t0_hi, size_field(c.width)} | T0_FIXED;
            OFF_T1:   r = {c.t1_hi, size_field(c.height)};
            OFF_T2:   r = c.t2 | T2_FIXED;
            OFF_STAT: begin
                r[6] = f.palette_done;
                r[2] = f.sync_err;
                r[0] = f.frame_done;
            end
            OFF_SUB:  r = c.subpanel;
            default:  r = '0;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/lcdr_cfg.sv
module lcdr_cfg
    import lcdr_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  wr_en,
    input  logic [REG_ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0]     wdata,
    output cfg_t                  cfg,
    output en_evt_t               evt
);
    logic wr_ctrl, wr_t0, wr_t1, wr_t2, wr_sub, wr_unmapped;

    always_comb begin
        wr_ctrl     = wr_en && (addr == OFF_CTRL);
        wr_t0       = wr_en && (addr == OFF_T0);
        wr_t1       = wr_en && (addr == OFF_T1);
        wr_t2       = wr_en && (addr == OFF_T2);
        wr_sub      = wr_en && (addr == OFF_SUB);
        wr_unmapped = wr_en && !wr_ctrl && !wr_t0 && !wr_t1 && !wr_t2 && !wr_sub
                      && (addr != OFF_STAT);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg <= '0;
        end else begin
            if (wr_ctrl) begin
                cfg.load_mode <= wdata[21:20];
                cfg.tft       <= wdata[7];
                cfg.irq_en    <= wdata[4:3];
                cfg.mono      <= wdata[1];
                cfg.enable    <= wdata[0];
                cfg.ctrl_rest <= wdata & CTRL_KEEP_MASK;
            end
            if (wr_t0) begin
                cfg.width <= size_from(wdata);
                cfg.t0_hi <= wdata[DATA_W-1:SIZE_FIELD_W];
            end
            if (wr_t1) begin
                cfg.height <= size_from(wdata);
                cfg.t1_hi  <= wdata[DATA_W-1:SIZE_FIELD_W];
            end
            if (wr_t2)  cfg.t2       <= wdata;
            if (wr_sub) cfg.subpanel <= wdata & SUB_KEEP_MASK;
        end
    end

    // Enable transitions are judged against the enable held before this write.
    always_comb begin
        evt.rise           = wr_ctrl &&  wdata[0] && !cfg.enable;
        evt.fall           = wr_ctrl && !wdata[0] &&  cfg.enable;
        evt.fall_sets_done = (wdata[21:20] != 2'd1);
    end

    p_size_range_r3: assert property (@(posedge clk) disable iff (rst)
        wr_t0 |=> (cfg.width != '0) && (cfg.width <= SIZE_W'(1 << SIZE_FIELD_W)));

    p_unmapped_inert_r1: assert property (@(posedge clk) disable iff (rst)
        wr_unmapped |=> $stable(cfg));

    p_enable_follows_r2: assert property (@(posedge clk) disable iff (rst)
        (wr_ctrl && wdata[0]) |=> cfg.enable);

endmodule

// File: rtl/lcdr_status.sv
module lcdr_status
    import lcdr_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  en_evt_t    evt,
    input  logic       set_frame_done,
    input  logic       set_palette_done,
    input  logic       set_sync_err,
    input  logic [1:0] irq_en,
    output flags_t     flags,
    output logic       irq
);
    flags_t flags_n;

    // Engine pulses first, the enable transition last so that it wins.
    always_comb begin
        flags_n              = flags;
        flags_n.frame_done   = flags.frame_done   | set_frame_done;
        flags_n.palette_done = flags.palette_done | set_palette_done;
        flags_n.sync_err     = flags.sync_err     | set_sync_err;
        if (evt.fall) begin
            flags_n.sync_err = 1'b0;
            if (evt.fall_sets_done) flags_n.frame_done = 1'b1;
        end
        if (evt.rise) begin
            flags_n.frame_done   = 1'b0;
            flags_n.palette_done = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            flags <= '0;
            irq   <= 1'b0;
        end else begin
            flags <= flags_n;
            irq   <= (flags.frame_done & irq_en[0]) |
                     (flags.palette_done & irq_en[1]) |
                     flags.sync_err;
        end
    end

    p_fall_clears_err_r7: assert property (@(posedge clk) disable iff (rst)
        evt.fall |=> !flags.sync_err);

    p_rise_clears_done_r8: assert property (@(posedge clk) disable iff (rst)
        evt.rise |=> (!flags.frame_done && !flags.palette_done));

    p_err_unmaskable_r6: assert property (@(posedge clk) disable iff (rst)
        flags.sync_err |=> irq);

    p_quiet_r6: assert property (@(posedge clk) disable iff (rst)
        (flags == '0) |=> !irq);

    p_pulse_sets_r9: assert property (@(posedge clk) disable iff (rst)
        (set_sync_err && !evt.fall) |=> flags.sync_err);

endmodule

// File: rtl/lcdr_readmux.sv
module lcdr_readmux
    import lcdr_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  rd_en,
    input  logic [REG_ADDR_W-1:0] addr,
    input  cfg_t                  cfg,
    input  flags_t                flags,
    output logic [DATA_W-1:0]     rdata
);
    always_ff @(posedge clk) begin
        if (rst)        rdata <= '0;
        else if (rd_en) rdata <= read_word(addr, cfg, flags);
    end

    p_unmapped_zero_r1: assert property (@(posedge clk) disable iff (rst)
        (rd_en && (addr > OFF_SUB || addr[1:0] != 2'b00)) |=> (rdata == '0));

    p_status_upper_zero_r5: assert property (@(posedge clk) disable iff (rst)
        (rd_en && addr == OFF_STAT) |=> (rdata[DATA_W-1:7] == '0));

    p_hold_r11: assert property (@(posedge clk) disable iff (rst)
        !rd_en |=> $stable(rdata));

endmodule

// File: rtl/panel_ctl_regs.sv
module panel_ctl_regs
    import lcdr_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  bus_wr,
    input  logic                  bus_rd,
    input  logic [REG_ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0]     bus_wdata,
    output logic [DATA_W-1:0]     bus_rdata,
    input  logic                  evt_frame_done,
    input  logic                  evt_palette_done,
    input  logic                  evt_sync_error,
    output logic                  irq,
    output logic [1:0]            load_mode,
    output logic                  tft,
    output logic                  mono,
    output logic                  enable,
    output logic [SIZE_W-1:0]     width,
    output logic [SIZE_W-1:0]     height,
    output logic [DATA_W-1:0]     subpanel
);
    cfg_t    cfg;
    en_evt_t en_evt;
    flags_t  flags;

    lcdr_cfg u_cfg (
        .clk   (clk),
        .rst   (rst),
        .wr_en (bus_wr),
        .addr  (bus_addr),
        .wdata (bus_wdata),
        .cfg   (cfg),
        .evt   (en_evt)
    );

    lcdr_status u_status (
        .clk              (clk),
        .rst              (rst),
        .evt              (en_evt),
        .set_frame_done   (evt_frame_done),
        .set_palette_done (evt_palette_done),
        .set_sync_err     (evt_sync_error),
        .irq_en           (cfg.irq_en),
        .flags            (flags),
        .irq              (irq)
    );

    lcdr_readmux u_rd (
        .clk   (clk),
        .rst   (rst),
        .rd_en (bus_rd),
        .addr  (bus_addr),
        .cfg   (cfg),
        .flags (flags),
        .rdata (bus_rdata)
    );

    always_comb begin
        load_mode = cfg.load_mode;
        tft       = cfg.tft;
        mono      = cfg.mono;
        enable    = cfg.enable;
        width     = cfg.width;
        height    = cfg.height;
        subpanel  = cfg.subpanel;
    end

    p_status_write_inert_r5: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == OFF_STAT && !evt_frame_done && !evt_palette_done
         && !evt_sync_error) |=> $stable(flags));

endmodule

// File: tb/panel_ctl_regs_tb.sv
`timescale 1ns/100ps
module panel_ctl_regs_tb;

    logic        clk = 1'b0;
    logic        rst;
    logic        bus_wr, bus_rd;
    logic [7:0]  bus_addr;
    logic [31:0] bus_wdata;
    logic [31:0] bus_rdata;
    logic        evt_fd, evt_pd, evt_se;
    logic        irq;
    logic [1:0]  load_mode;
    logic        tft, mono, enable;
    logic [10:0] width, height;
    logic [31:0] subpanel;

    int errors = 0;
    int checks = 0;
    bit done = 0;

    // reference model state
    int unsigned m_lm, m_tft, m_ie, m_mono, m_en, m_ctrl;
    int          m_w, m_h;
    int unsigned m_t0hi, m_t1hi, m_t2, m_sub;
    bit          m_fd, m_pd, m_se;

    always #2.5 clk = ~clk;

    panel_ctl_regs u_dut (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .evt_frame_done(evt_fd), .evt_palette_done(evt_pd), .evt_sync_error(evt_se),
        .irq(irq), .load_mode(load_mode), .tft(tft), .mono(mono), .enable(enable),
        .width(width), .height(height), .subpanel(subpanel)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%08h expected=%08h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] exp_read(input logic [7:0] a);
        logic [31:0] r;
        case (a)
            8'h00: r = (m_tft << 23) | (m_lm << 20) | (m_tft << 7) | (m_ie << 3) |
                       (m_mono << 1) | m_en | m_ctrl | 32'hFE000C34;
            8'h04: r = (m_t0hi << 10) | ((m_w - 1) & 32'h3FF) | 32'hF;
            8'h08: r = (m_t1hi << 10) | ((m_h - 1) & 32'h3FF);
            8'h0C: r = m_t2 | 32'hFC000000;
            8'h10: r = (32'(m_pd) << 6) | (32'(m_se) << 2) | 32'(m_fd);
            8'h14: r = m_sub;
            default: r = 32'h0;
        endcase
        return r;
    endfunction

    function automatic logic exp_irq();
        return (m_fd && m_ie[0]) || (m_pd && m_ie[1]) || m_se;
    endfunction

    task automatic model_reset();
        m_lm = 0; m_tft = 0; m_ie = 0; m_mono = 0; m_en = 0; m_ctrl = 0;
        m_w = 0; m_h = 0; m_t0hi = 0; m_t1hi = 0; m_t2 = 0; m_sub = 0;
        m_fd = 0; m_pd = 0; m_se = 0;
    endtask

    // pulses land first, then the enable transition of a control write
    task automatic model_cycle(input bit wr, input logic [7:0] a, input logic [31:0] d,
                               input bit pf, input bit pp, input bit ps);
        int unsigned ne;
        if (pf) m_fd = 1;
        if (pp) m_pd = 1;
        if (ps) m_se = 1;
        if (wr) begin
            case (a)
                8'h00: begin
                    ne = d[0];
                    m_lm = d[21:20]; m_tft = d[7]; m_ie = d[4:3]; m_mono = d[1];
                    m_ctrl = d & 32'h01CFF300;
                    if (ne != m_en) begin
                        if (ne == 0) begin
                            m_se = 0;
                            if (m_lm != 1) m_fd = 1;
                        end else begin
                            m_fd = 0; m_pd = 0;
                        end
                    end
                    m_en = ne;
                end
                8'h04: begin m_w = int'(d[9:0]) + 1; m_t0hi = d[31:10]; end
                8'h08: begin m_h = int'(d[9:0]) + 1; m_t1hi = d[31:10]; end
                8'h0C: m_t2 = d;
                8'h14: m_sub = d & 32'hA1FFFFFF;
                default: ;
            endcase
        end
    endtask

    // one bus cycle, entered and left at a falling edge
    task automatic cyc(input bit wr, input bit rd, input logic [7:0] a, input logic [31:0] d,
                       input bit pf, input bit pp, input bit ps, input string req);
        logic [31:0] er;
        er = exp_read(a);
        bus_wr = wr; bus_rd = rd; bus_addr = a; bus_wdata = d;
        evt_fd = pf; evt_pd = pp; evt_se = ps;
        @(posedge clk);
        model_cycle(wr, a, d, pf, pp, ps);
        @(negedge clk);
        bus_wr = 0; bus_rd = 0; evt_fd = 0; evt_pd = 0; evt_se = 0;
        if (rd) chk(req, bus_rdata, er);
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        cyc(1, 0, a, d, 0, 0, 0, "");
    endtask

    task automatic rd(input logic [7:0] a, input string req);
        cyc(0, 1, a, 32'h0, 0, 0, 0, req);
    endtask

    task automatic pulse(input bit pf, input bit pp, input bit ps);
        cyc(0, 0, 8'h00, 32'h0, pf, pp, ps, "");
    endtask

    task automatic chk_irq(input string req);
        cyc(0, 0, 8'h00, 32'h0, 0, 0, 0, "");
        chk(req, {31'b0, irq}, {31'b0, exp_irq()});
    endtask

    task automatic read_all(input string req);
        for (int i = 0; i < 6; i++) rd(8'(i * 4), req);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        logic [7:0]  a;
        int unsigned seed;
        seed = 32'h5EED_1234;
        v = $urandom(seed);
        rst = 1; bus_wr = 0; bus_rd = 0; bus_addr = 0; bus_wdata = 0;
        evt_fd = 0; evt_pd = 0; evt_se = 0;
        model_reset();
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);

        // R10 reset state
        chk("R10 rdata", bus_rdata, 32'h0);
        chk("R10 irq", {31'b0, irq}, 32'h0);
        chk("R10 width", {21'b0, width}, 32'h0);
        chk("R10 height", {21'b0, height}, 32'h0);
        chk("R10 subpanel", subpanel, 32'h0);
        rd(8'h00, "R10 ctrl"); chk("R10 ctrl const", bus_rdata, 32'hFE000C34);
        rd(8'h04, "R10 t0");   chk("R10 t0 const", bus_rdata, 32'h000003FF);
        rd(8'h08, "R10 t1");   chk("R10 t1 const", bus_rdata, 32'h000003FF);
        rd(8'h0C, "R10 t2");   chk("R10 t2 const", bus_rdata, 32'hFC000000);
        rd(8'h10, "R10 status");

        // R2 control decode
        wr(8'h00, 32'h0030_0082);
        rd(8'h00, "R2 ctrl readback");
        chk("R2 load_mode", {30'b0, load_mode}, 32'h3);
        chk("R2 tft", {31'b0, tft}, 32'h1);
        chk("R2 mono", {31'b0, mono}, 32'h1);
        wr(8'h00, 32'hFFFF_FFFF);
        rd(8'h00, "R2 ctrl all ones");
        chk("R2 enable", {31'b0, enable}, 32'h1);

        // R3 size boundaries
        wr(8'h04, 32'hABCD_E3FF);
        chk("R3 width max", {21'b0, width}, 32'd1024);
        rd(8'h04, "R3 t0 max");
        wr(8'h04, 32'h0000_0400);
        chk("R3 width min", {21'b0, width}, 32'd1);
        rd(8'h04, "R3 t0 min");
        wr(8'h08, 32'h1234_5123);
        chk("R3 height", {21'b0, height}, 32'h124);
        rd(8'h08, "R3 t1");

        // R4 timing2 and subpanel
        wr(8'h0C, 32'h0123_4567); rd(8'h0C, "R4 t2");
        wr(8'h14, 32'hFFFF_FFFF); rd(8'h14, "R4 sub");
        chk("R4 sub port", subpanel, 32'hA1FFFFFF);

        // R5 status layout and inert writes; R6 masking (enable stays 1)
        wr(8'h00, 32'h0000_0001);           // ie=0, enabled
        pulse(1, 1, 0);
        rd(8'h10, "R5 status fd pd");
        chk_irq("R6 masked");
        wr(8'h10, 32'h0000_0000);
        rd(8'h10, "R5 status write ignored");
        wr(8'h00, 32'h0000_0009);           // ie bit0
        chk_irq("R6 frame enable");
        wr(8'h00, 32'h0000_0011);           // ie bit1
        chk_irq("R6 palette enable");

        // R8 rise clears done flags; R7 fall behaviour
        wr(8'h00, 32'h0000_0000);           // fall, lm 0 -> fd set, se cleared
        rd(8'h10, "R7 fall lm0");
        wr(8'h00, 32'h0000_0001);           // rise
        rd(8'h10, "R8 rise clears");
        pulse(0, 0, 1);
        chk_irq("R6 sync unmaskable");
        wr(8'h00, 32'h0010_0000);           // fall with lm 1
        rd(8'h10, "R7 fall lm1");
        chk_irq("R7 irq after fall");
        pulse(0, 1, 0);
        wr(8'h00, 32'h0000_0018);           // enable unchanged at 0
        rd(8'h10, "R7 no transition");

        // R9 collisions
        wr(8'h00, 32'h0000_0001);
        cyc(1, 0, 8'h00, 32'h0010_0000, 0, 0, 1, "");
        rd(8'h10, "R9 fall beats sync pulse");
        cyc(1, 0, 8'h00, 32'h0000_0019, 1, 1, 0, "");
        rd(8'h10, "R9 rise beats done pulses");
        chk_irq("R9 irq");

        // R1 unmapped offsets
        wr(8'h18, 32'hFFFF_FFFF);
        wr(8'h01, 32'hFFFF_FFFF);
        wr(8'hFC, 32'h0000_0000);
        read_all("R1 unmapped write inert");
        rd(8'h18, "R1 unmapped read");
        rd(8'h02, "R1 unaligned read");

        // R11 read/write same cycle and hold
        cyc(1, 1, 8'h0C, 32'h5555_AAAA, 0, 0, 0, "R11 old value");
        v = bus_rdata;
        pulse(0, 0, 0);
        chk("R11 hold", bus_rdata, v);
        rd(8'h0C, "R11 new value");

        // random phase
        for (int i = 0; i < 400; i++) begin
            int unsigned k;
            k = $urandom % 8;
            a = (k < 7) ? 8'(k * 4) : 8'($urandom);
            v = $urandom;
            case ($urandom % 4)
                0: cyc(1, 0, a, v, ($urandom % 4) == 0, ($urandom % 4) == 0,
                       ($urandom % 6) == 0, "");
                1: cyc(0, 1, a, 32'h0, ($urandom % 4) == 0, 0, 0, "R1 R2 R3 R4 R5 random read");
                2: cyc(1, 1, a, v, 0, 0, 0, "R11 random rw");
                default: chk_irq("R6 random irq");
            endcase
        end
        read_all("R9 random final");
        chk_irq("R6 final");

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule